// File: doc/BRIEF.md
# Integer Twin-Butterfly Multiply-Round Unit

This block computes one butterfly step of a fixed-point DCT or FFT kernel in a single pipelined operation. It takes two signed data words `a` and `b`, one signed coefficient `c` and a shift amount `sh`. It forms both the sum `a+b` and the difference `a-b`, and multiplies each by `c`. Each product is rounded to nearest, with halves rounded upward, and then scaled down by an arithmetic right shift. The two results leave the block together: the sum-path result is meant for the primary destination, and the difference-path result for the secondary destination.

Without this block, the same work takes eight separate integer operations: an add, a subtract, two multiplies, two rounding adds and two right shifts. The datapath is three stages deep: add/subtract, then multiply, then round and shift. A valid/ready handshake sits on each side. The unit takes one new operation every cycle unless the consumer holds off the result.

Top module: `twin_bfly_mr`

## Requirements
- R1: `out_sum` equals `((a+b)*c + bias) >>> sh`, where only the low W bits of the product are kept and `bias` is `2^(sh-1)`.
- R2: `out_dif` equals `((a-b)*c + bias) >>> sh`, using the same coefficient, bias and shift as R1.
- R3: The sum, difference, product and rounding add all wrap modulo 2^W, with no saturation. For example, the most negative value plus -1 gives the most positive value.
- R4: When `sh` is 0 the bias is 0, so each output is the raw low product word.
- R5: The shift is arithmetic and is never a rotate. High product bits never appear in the low result bits. With `sh` = W-1, each output is either all zeros or all ones.
- R6: With `c` = 0, both outputs are 0 for every shift amount. With `c` = -1 and `sh` = 0, the outputs are the two's-complement negations of `a+b` and `a-b`.
- R7: An operation accepted at a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after the third edge, counting the accepting edge as the first. With `out_ready` held high, one operation is accepted every cycle.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid`, `out_sum` and `out_dif` hold their values.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted at this edge when `in_valid` is high |
| in_a | input | W | First data operand, signed |
| in_b | input | W | Second data operand, signed |
| in_c | input | W | Coefficient, signed |
| in_sh | input | $clog2(W) | Right-shift amount |
| out_valid | output | 1 | Result pair present |
| out_ready | input | 1 | Consumer takes the result pair |
| out_sum | output | W | Sum-path result, for the primary destination |
| out_dif | output | W | Difference-path result, for the secondary destination |

## Verification
The hardest case to reach from the ports is a full pipeline held by back-pressure. In that case all three stages hold valid data at once, and the oldest result must stay fixed while new operations wait at the input. To get there, the bench streams operations back to back and drops `out_ready` at random. Every accepted operation is matched, in order, against an independent floor-division model. The corner operands include values that make the rounding add itself overflow the word. A shift of W-1 applied to such a value exposes any rotate in place of a true shift.

// File: rtl/twin_bfly_pkg.sv
package twin_bfly_pkg;

  // Half-LSB rounding bias for a right shift of sh bits; zero for sh == 0.
  function automatic logic [63:0] half_lsb(input int unsigned sh);
    if (sh == 0) return 64'd0;
    return 64'd1 << (sh - 1);
  endfunction

  // Low word of a signed product, returned in a 64-bit container.
  function automatic logic [63:0] prod_lo(input logic signed [63:0] x,
                                          input logic signed [63:0] c);
    return x * c;
  endfunction

endpackage

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  v_in,
  input  logic signed [W-1:0]   a,
  input  logic signed [W-1:0]   b,
  input  logic signed [W-1:0]   c,
  input  logic [SHW-1:0]        sh,
  output logic                  v_q,
  output logic signed [W-1:0]   sum_q,
  output logic signed [W-1:0]   dif_q,
  output logic signed [W-1:0]   c_q,
  output logic [SHW-1:0]        sh_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= 1'b0;
    else if (en) v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sum_q <= a + b;
      dif_q <= a - b;
      c_q   <= c;
      sh_q  <= sh;
    end
  end

  // R1/R2: with b == 0 both lanes see the same intermediate
  a_r1_zero_b_lanes_match: assert property (@(posedge clk) disable iff (!rst_n)
    (en && v_in && b == '0) |=> (sum_q == dif_q));

endmodule

// File: rtl/bfly_mul.sv
module bfly_mul #(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  v_in,
  input  logic signed [W-1:0]   sum_in,
  input  logic signed [W-1:0]   dif_in,
  input  logic signed [W-1:0]   c_in,
  input  logic [SHW-1:0]        sh_in,
  output logic                  v_q,
  output logic signed [W-1:0]   psum_q,
  output logic signed [W-1:0]   pdif_q,
  output logic [SHW-1:0]        sh_q
);
  import twin_bfly_pkg::*;

  logic [63:0] psum_full, pdif_full;

  always_comb begin
    psum_full = prod_lo(64'(sum_in), 64'(c_in));
    pdif_full = prod_lo(64'(dif_in), 64'(c_in));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= 1'b0;
    else if (en) v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      psum_q <= psum_full[W-1:0];
      pdif_q <= pdif_full[W-1:0];
      sh_q   <= sh_in;
    end
  end

  // R6: zero coefficient yields zero products on both lanes
  a_r6_zero_coef: assert property (@(posedge clk) disable iff (!rst_n)
    (en && v_in && c_in == '0) |=> (psum_q == '0 && pdif_q == '0));

endmodule

// File: rtl/bfly_round_shift.sv
module bfly_round_shift #(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  v_in,
  input  logic signed [W-1:0]   psum_in,
  input  logic signed [W-1:0]   pdif_in,
  input  logic [SHW-1:0]        sh_in,
  output logic                  v_q,
  output logic signed [W-1:0]   rsum_q,
  output logic signed [W-1:0]   rdif_q
);
  import twin_bfly_pkg::*;

  localparam int LANES = 2;

  logic [63:0]         bias_full;
  logic signed [W-1:0] bias;
  logic signed [W-1:0] lane_p   [LANES];
  logic signed [W-1:0] lane_res [LANES];

  always_comb begin
    bias_full = half_lsb(int'(sh_in));
    bias      = bias_full[W-1:0];
    lane_p[0] = psum_in;
    lane_p[1] = pdif_in;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [W-1:0] rounded;
    always_comb begin
      rounded     = lane_p[g] + bias;
      lane_res[g] = rounded >>> sh_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= 1'b0;
    else if (en) v_q <= v_in;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      rsum_q <= lane_res[0];
      rdif_q <= lane_res[1];
    end
  end

  // R4: no shift means the raw low product word passes through
  a_r4_sh0_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (en && v_in && sh_in == '0) |=> (rsum_q == $past(psum_in) && rdif_q == $past(pdif_in)));

  // R5: a full-width shift leaves only sign copies
  a_r5_max_shift_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (en && v_in && sh_in == SHW'(W-1)) |=>
      ((rsum_q == '0 || rsum_q == '1) && (rdif_q == '0 || rdif_q == '1)));

endmodule

// File: rtl/twin_bfly_mr.sv
module twin_bfly_mr #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [W-1:0]  in_a,
  input  logic signed [W-1:0]  in_b,
  input  logic signed [W-1:0]  in_c,
  input  logic [SHW-1:0]       in_sh,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [W-1:0]  out_sum,
  output logic signed [W-1:0]  out_dif
);

  // whole pipe advances together unless the output slot is held
  logic adv;
  logic accept;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign accept   = in_valid && adv;

  logic                s1_v, s2_v;
  logic signed [W-1:0] s1_sum, s1_dif, s1_c;
  logic [SHW-1:0]      s1_sh, s2_sh;
  logic signed [W-1:0] s2_psum, s2_pdif;

  bfly_addsub #(.W(W), .SHW(SHW)) u_addsub (
    .clk(clk), .rst_n(rst_n), .en(adv), .v_in(in_valid),
    .a(in_a), .b(in_b), .c(in_c), .sh(in_sh),
    .v_q(s1_v), .sum_q(s1_sum), .dif_q(s1_dif), .c_q(s1_c), .sh_q(s1_sh)
  );

  bfly_mul #(.W(W), .SHW(SHW)) u_mul (
    .clk(clk), .rst_n(rst_n), .en(adv), .v_in(s1_v),
    .sum_in(s1_sum), .dif_in(s1_dif), .c_in(s1_c), .sh_in(s1_sh),
    .v_q(s2_v), .psum_q(s2_psum), .pdif_q(s2_pdif), .sh_q(s2_sh)
  );

  bfly_round_shift #(.W(W), .SHW(SHW)) u_rsh (
    .clk(clk), .rst_n(rst_n), .en(adv), .v_in(s2_v),
    .psum_in(s2_psum), .pdif_in(s2_pdif), .sh_in(s2_sh),
    .v_q(out_valid), .rsum_q(out_sum), .rdif_q(out_dif)
  );

  // R8: a held result stays put
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_dif)));

  // R7: an accepted operation reaches the multiply stage next cycle
  a_r7_accept_flows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> s1_v);

  // R7: a valid multiply-stage entry that advances becomes an output
  a_r7_stage_to_out: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && adv) |=> out_valid);

endmodule

// File: tb/twin_bfly_mr_tb.sv
module twin_bfly_mr_tb;

  localparam int W = 32;
  localparam int SHW = 5;
  localparam int NTAB = 12;
  localparam int NRND = 300;
  localparam int QN = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [W-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic [SHW-1:0] in_sh = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [W-1:0] out_sum, out_dif;

  always #2.5 clk = ~clk;

  twin_bfly_mr #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_sh(in_sh),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_dif(out_dif)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit bp_en = 0;

  // expected-result queue
  logic [W-1:0] q_sum [QN];
  logic [W-1:0] q_dif [QN];
  string        q_tag [QN];
  int wr_idx = 0;
  int rd_idx = 0;

  typedef struct packed {
    logic [31:0] a, b, c;
    logic [4:0]  sh;
    logic [31:0] es, ed;
  } vec_t;

  // a, b, c, sh, expected sum-path, expected difference-path
  localparam vec_t TBL [NTAB] = '{
    '{32'd3,        32'd1,        32'd2,        5'd0,  32'd8,        32'd4},
    '{32'd100,      -32'sd20,     32'd3,        5'd1,  32'd120,      32'd180},
    '{-32'sd5,      32'd0,        32'd1,        5'd1,  -32'sd2,      -32'sd2},
    '{32'd10000,    32'd6384,     32'd8192,     5'd14, 32'd8192,     32'd1808},
    '{32'd7,        32'd9,        32'd0,        5'd5,  32'd0,        32'd0},
    '{32'd7,        32'd2,        32'hFFFFFFFF, 5'd0,  -32'sd9,      -32'sd5},
    '{32'h80000000, 32'hFFFFFFFF, 32'd1,        5'd0,  32'h7FFFFFFF, 32'h80000001},
    '{32'h40000000, 32'h40000000, 32'd1,        5'd31, 32'hFFFFFFFF, 32'd0},
    '{32'd7,        32'd0,        32'd1,        5'd2,  32'd2,        32'd2},
    '{32'h00010000, 32'd0,        32'h00010000, 5'd0,  32'd0,        32'd0},
    '{32'h80000000, 32'd0,        32'hFFFFFFFF, 5'd0,  32'h80000000, 32'h80000000},
    '{32'h7FFFFFFF, 32'd0,        32'd1,        5'd31, 32'hFFFFFFFF, 32'hFFFFFFFF}
  };

  function automatic string tbl_tag(int i);
    case (i)
      0, 8:     return "R4/R5";
      1, 2:     return "R1/R2";
      3:        return "R1";
      4:        return "R6";
      5:        return "R6 neg";
      6, 9, 10: return "R3";
      default:  return "R5";
    endcase
  endfunction

  // floor-division model of one lane
  function automatic logic [W-1:0] ref_lane(int x, int c, int sh);
    longint p, r, d, q;
    int pw, rw;
    p  = longint'(x) * longint'(c);
    pw = int'(p);
    r  = longint'(pw) + ((sh > 0) ? (longint'(1) << (sh - 1)) : 0);
    rw = int'(r);
    d  = longint'(1) << sh;
    q  = longint'(rw) / d;
    if ((longint'(rw) % d) < 0) q = q - 1;
    return q[W-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at posedge+1; returns at posedge+1 after acceptance
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] c, input int sh,
                      input logic [W-1:0] es, input logic [W-1:0] ed,
                      input string tag);
    in_a = a; in_b = b; in_c = c; in_sh = SHW'(sh); in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    q_sum[wr_idx % QN] = es;
    q_dif[wr_idx % QN] = ed;
    q_tag[wr_idx % QN] = tag;
    wr_idx++;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_model(input int a, input int b, input int c, input int sh,
                            input string tag);
    int s, d;
    s = a + b;
    d = a - b;
    send(a, b, c, sh, ref_lane(s, c, sh), ref_lane(d, c, sh), tag);
  endtask

  // collector: transfer happens at the next edge, so check mid-cycle
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (rd_idx >= wr_idx) begin
        check(1'b0, "R7 unexpected output", out_sum, '0);
      end else begin
        check(out_sum == q_sum[rd_idx % QN], {q_tag[rd_idx % QN], " R1 sum"},
              out_sum, q_sum[rd_idx % QN]);
        check(out_dif == q_dif[rd_idx % QN], {q_tag[rd_idx % QN], " R2 dif"},
              out_dif, q_dif[rd_idx % QN]);
        rd_idx++;
      end
    end
    if (rst_n && out_valid && !out_ready) begin
      check(!in_ready, "R8 in_ready low while held", {31'd0, in_ready}, '0);
    end
  end

  // back-pressure generator
  initial begin
    forever begin
      @(posedge clk); #1;
      if (bp_en) out_ready = ($urandom % 3) != 0;
      else out_ready = 1'b1;
    end
  end

  // R8: held output stays stable across a stalled cycle
  logic [W-1:0] held_sum, held_dif;
  bit held_vld = 0;
  always @(negedge clk) begin
    if (rst_n && held_vld) begin
      check(out_valid && out_sum == held_sum && out_dif == held_dif,
            "R8 held result stable", out_sum, held_sum);
    end
    held_vld = rst_n && out_valid && !out_ready;
    held_sum = out_sum;
    held_dif = out_dif;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd_idx, wr_idx);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R9 out_valid after reset", {31'd0, out_valid}, '0);
    check(in_ready, "R9 in_ready after reset", {31'd0, in_ready}, 1);
    @(posedge clk); #1;

    // table walk, back to back
    for (int i = 0; i < NTAB; i++) begin
      send(TBL[i].a, TBL[i].b, TBL[i].c, int'(TBL[i].sh), TBL[i].es, TBL[i].ed,
           tbl_tag(i));
    end
    repeat (5) @(posedge clk);
    #1;

    // R7: latency with an idle pipe
    in_a = 32'd4; in_b = 32'd2; in_c = 32'd5; in_sh = '0; in_valid = 1'b1;
    q_sum[wr_idx % QN] = 32'd30;
    q_dif[wr_idx % QN] = 32'd10;
    q_tag[wr_idx % QN] = "R7";
    wr_idx++;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(!out_valid, "R7 not valid after edge 1", {31'd0, out_valid}, '0);
    @(negedge clk);
    check(!out_valid, "R7 not valid after edge 2", {31'd0, out_valid}, '0);
    @(negedge clk);
    check(out_valid, "R7 valid after edge 3", {31'd0, out_valid}, 1);
    @(posedge clk); #1;

    // directed corners through the model
    send_model(32'h80000000, 32'h80000000, -1, 0, "R3");
    send_model(-1, 0, 1, 31, "R5");
    send_model(32'h12345678, 32'h0F0F0F0F, 32'h00FF00FF, 14, "R5");
    send_model(-12345, 678, 0, 31, "R6");
    send_model(32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, "R3");

    // random stream under back-pressure
    bp_en = 1;
    for (int i = 0; i < NRND; i++) begin
      int a, b, c, sh, pick;
      a = $urandom; b = $urandom; c = $urandom;
      pick = $urandom % 8;
      case (pick)
        0: sh = 0;
        1: sh = 14;
        2: sh = 31;
        default: sh = $urandom % 32;
      endcase
      case ($urandom % 10)
        0: c = 0;
        1: c = -1;
        2: a = 32'h80000000;
        3: b = 32'h80000000;
        default: ;
      endcase
      send_model(a, b, c, sh, "R1/R2 random");
    end
    bp_en = 0;

    while (rd_idx < wr_idx) @(posedge clk);
    repeat (2) @(posedge clk);
    check(rd_idx == wr_idx, "R7 all results delivered", rd_idx, wr_idx);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule